// File: doc/BRIEF.md
# Dual-parallel QSPI data interleaver

This block sits between a controller that serializes for a single quad-SPI flash and a pair of identical flash devices wired side by side. The two devices run from one shared clock and are selected together, but each has its own 4-bit IO bus. With the pair behaving as one device of twice the width, a quad data phase moves a whole byte in each SCLK cycle. The even-numbered bits of the byte go to the lower device and the odd-numbered bits go to the upper device.

Command and address phases are sent to both devices unchanged, so each device sees the same command. On reads the block samples both nibble buses on the SCLK edge that the controller marks. It weaves the two nibbles back into one byte and presents that byte with a single-cycle valid strobe. Two configuration fields must both be set to enable the mode: the separate-bus field (bit 29 of the controller's configuration register) and the two-memory field (bit 30). Otherwise the block passes the controller's signals to the lower device only and keeps the upper device deselected.

All pin outputs are registered, so they follow the controller inputs with one clock of latency. The controller phase input uses this encoding: 2'b00 command/address, 2'b01 write data, 2'b10 turnaround/dummy, 2'b11 read data.

Top module: `qspi_dual_lane_mux`

## Requirements
- R1: The paired mode is active only when cfg_sep_bus and cfg_two_mem are both 1. With either one at 0, the block behaves exactly as in single mode (R6).
- R2: In paired mode with phase 2'b01 and the logical select low, one clock later lo_io_o = {b6,b4,b2,b0} and up_io_o = {b7,b5,b3,b1} of ctl_wbyte, with the higher-indexed bit on IO[3], and both output enables are 4'hF.
- R3: In paired mode, lo_cs_n and up_cs_n both equal the previous cycle's ctl_cs_n, so they assert and deassert on the same cycle.
- R4: In paired mode with phase 2'b00, both buses drive the previous cycle's ctl_io_out, each with ctl_io_oe as its enables.
- R5: In paired mode, a cycle with ctl_tick=1, phase 2'b11 and the select low samples both input buses. In the next cycle rd_valid is 1 for exactly one cycle, and rd_byte has bit 2k equal to lo_io_i[k] and bit 2k+1 equal to up_io_i[k]. rd_valid is 0 in the cycle after any other cycle.
- R6: In single mode, up_cs_n stays 1 and up_io_oe stays 0. The lower bus carries ctl_io_out and ctl_io_oe in every driven phase, including write data, where ctl_wbyte has no effect. ctl_io_in always equals lo_io_i.
- R7: With phase 2'b10 or 2'b11 and the select low, both buses have output enable 0 from the next cycle on.
- R8: A chip-select output that is high is paired with an output enable of 0 and an output value of 0 on its bus.
- R9: During reset both chip-selects are 1, all output enables are 0 and rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one cycle per SCLK period |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sep_bus | input | 1 | Separate-bus configuration field (register bit 29) |
| cfg_two_mem | input | 1 | Two-memory configuration field (register bit 30) |
| ctl_cs_n | input | 1 | Logical chip-select from the controller, active low |
| ctl_phase | input | 2 | Phase: 00 cmd/addr, 01 write data, 10 turnaround, 11 read data |
| ctl_io_out | input | 4 | Serialized single-device output nibble |
| ctl_io_oe | input | 4 | Per-bit output enables for ctl_io_out |
| ctl_wbyte | input | 8 | Write byte for a paired data cycle |
| ctl_tick | input | 1 | Marks the SCLK edge on which read data is sampled |
| ctl_io_in | output | 4 | Lower bus input returned to the controller |
| rd_byte | output | 8 | Merged read byte |
| rd_valid | output | 1 | One-cycle strobe for rd_byte |
| lo_cs_n | output | 1 | Lower device chip-select |
| lo_io_o | output | 4 | Lower bus output value |
| lo_io_oe | output | 4 | Lower bus output enables |
| lo_io_i | input | 4 | Lower bus input value |
| up_cs_n | output | 1 | Upper device chip-select |
| up_io_o | output | 4 | Upper bus output value |
| up_io_oe | output | 4 | Upper bus output enables |
| up_io_i | input | 4 | Upper bus input value |

## Verification
The bench writes bytes that tell a parity swap or a bit reversal within a nibble apart. Examples are 0x01, 0x02, 0x80 and 0xA5: a design that sent bits to the wrong device, or put b6 on IO[0], would show a lone bit on the wrong bus or the wrong pin. It turns on only one of the two configuration fields to catch a design that enables the mode on an OR of the fields. Such a design would select the upper device or drive the write byte instead of passing ctl_io_out through. Read strobes are checked for both timing and pulse width: a strobe in the sampling cycle itself, or one held for two cycles, fails. Random select toggling in every phase catches a bus that keeps driving after its select deasserts.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  localparam int QDL_NIB_W = 4;

  typedef enum logic [1:0] {
    PH_CMD   = 2'b00,
    PH_WDATA = 2'b01,
    PH_TURN  = 2'b10,
    PH_RDATA = 2'b11
  } qdl_phase_e;
endpackage

// File: rtl/qdl_lane.sv
module qdl_lane
  import qdl_pkg::*;
#(
  parameter int NIB_W = QDL_NIB_W,
  parameter bit UPPER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_en,
  input  logic             host_cs_n,
  input  logic [1:0]       phase,
  input  logic [NIB_W-1:0] cmd_o,
  input  logic [NIB_W-1:0] cmd_oe,
  input  logic [NIB_W-1:0] wr_nib,
  output logic             pin_cs_n,
  output logic [NIB_W-1:0] pin_o,
  output logic [NIB_W-1:0] pin_oe
);
  logic             lane_on;
  logic             cs_n_d;
  logic [NIB_W-1:0] o_d;
  logic [NIB_W-1:0] oe_d;

  assign lane_on = UPPER ? dual_en : 1'b1;

  always_comb begin
    cs_n_d = 1'b1;
    o_d    = '0;
    oe_d   = '0;
    if (!host_cs_n && lane_on) begin
      cs_n_d = 1'b0;
      unique case (qdl_phase_e'(phase))
        PH_CMD: begin
          o_d  = cmd_o;
          oe_d = cmd_oe;
        end
        PH_WDATA: begin
          if (dual_en) begin
            o_d  = wr_nib;
            oe_d = '1;
          end else begin
            o_d  = cmd_o;
            oe_d = cmd_oe;
          end
        end
        default: begin
          o_d  = '0;
          oe_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_cs_n <= 1'b1;
      pin_o    <= '0;
      pin_oe   <= '0;
    end else begin
      pin_cs_n <= cs_n_d;
      pin_o    <= o_d;
      pin_oe   <= oe_d;
    end
  end
endmodule

// File: rtl/qdl_rd_merge.sv
module qdl_rd_merge
  import qdl_pkg::*;
#(
  parameter int NIB_W = QDL_NIB_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [NIB_W-1:0]  lo_i,
  input  logic [NIB_W-1:0]  up_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] woven;

  always_comb begin
    for (int k = 0; k < NIB_W; k++) begin
      woven[2*k]     = lo_i[k];
      woven[2*k + 1] = up_i[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= sample;
      if (sample) byte_o <= woven;
    end
  end
endmodule

// File: rtl/qspi_dual_lane_mux.sv
module qspi_dual_lane_mux
  import qdl_pkg::*;
#(
  parameter int NIB_W = QDL_NIB_W,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sep_bus,
  input  logic              cfg_two_mem,
  input  logic              ctl_cs_n,
  input  logic [1:0]        ctl_phase,
  input  logic [NIB_W-1:0]  ctl_io_out,
  input  logic [NIB_W-1:0]  ctl_io_oe,
  input  logic [BYTE_W-1:0] ctl_wbyte,
  input  logic              ctl_tick,
  output logic [NIB_W-1:0]  ctl_io_in,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_valid,
  output logic              lo_cs_n,
  output logic [NIB_W-1:0]  lo_io_o,
  output logic [NIB_W-1:0]  lo_io_oe,
  input  logic [NIB_W-1:0]  lo_io_i,
  output logic              up_cs_n,
  output logic [NIB_W-1:0]  up_io_o,
  output logic [NIB_W-1:0]  up_io_oe,
  input  logic [NIB_W-1:0]  up_io_i
);
  // named internal events, observed by the checker
  logic dual_en;
  logic rd_sample;

  logic             lane_cs_n [LANES];
  logic [NIB_W-1:0] lane_o    [LANES];
  logic [NIB_W-1:0] lane_oe   [LANES];
  logic [NIB_W-1:0] lane_wr   [LANES];

  assign dual_en   = cfg_sep_bus & cfg_two_mem;
  assign rd_sample = dual_en & ~ctl_cs_n & ctl_tick &
                     (qdl_phase_e'(ctl_phase) == PH_RDATA);

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    for (genvar gk = 0; gk < NIB_W; gk++) begin : g_bit
      assign lane_wr[gi][gk] = ctl_wbyte[2*gk + gi];
    end

    qdl_lane #(
      .NIB_W (NIB_W),
      .UPPER (gi == 1)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .dual_en   (dual_en),
      .host_cs_n (ctl_cs_n),
      .phase     (ctl_phase),
      .cmd_o     (ctl_io_out),
      .cmd_oe    (ctl_io_oe),
      .wr_nib    (lane_wr[gi]),
      .pin_cs_n  (lane_cs_n[gi]),
      .pin_o     (lane_o[gi]),
      .pin_oe    (lane_oe[gi])
    );
  end

  assign lo_cs_n  = lane_cs_n[0];
  assign lo_io_o  = lane_o[0];
  assign lo_io_oe = lane_oe[0];
  assign up_cs_n  = lane_cs_n[1];
  assign up_io_o  = lane_o[1];
  assign up_io_oe = lane_oe[1];

  assign ctl_io_in = lo_io_i;

  qdl_rd_merge #(.NIB_W(NIB_W)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (rd_sample),
    .lo_i    (lo_io_i),
    .up_i    (up_io_i),
    .byte_o  (rd_byte),
    .valid_o (rd_valid)
  );
endmodule

// File: rtl/qspi_dual_lane_mux_chk.sv
module qspi_dual_lane_mux_chk #(
  parameter int NIB_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dual_en,
  input logic               rd_sample,
  input logic               ctl_cs_n,
  input logic [1:0]         ctl_phase,
  input logic [2*NIB_W-1:0] ctl_wbyte,
  input logic               rd_valid,
  input logic               lo_cs_n,
  input logic [NIB_W-1:0]   lo_io_o,
  input logic [NIB_W-1:0]   lo_io_oe,
  input logic               up_cs_n,
  input logic [NIB_W-1:0]   up_io_o,
  input logic [NIB_W-1:0]   up_io_oe
);
  AST_CS_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    dual_en |=> (lo_cs_n == up_cs_n)); // R3

  AST_UPPER_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |=> (up_cs_n && up_io_oe == '0)); // R6

  AST_LO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cs_n |-> (lo_io_oe == '0 && lo_io_o == '0)); // R8

  AST_UP_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    up_cs_n |-> (up_io_oe == '0 && up_io_o == '0)); // R8

  AST_RD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> rd_valid); // R5

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sample |=> !rd_valid); // R5

  AST_TURN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_cs_n && ctl_phase[1]) |=> (lo_io_oe == '0 && up_io_oe == '0)); // R7

  AST_WR_EVEN_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_en && !ctl_cs_n && ctl_phase == 2'b01) |=>
      (lo_io_o[0] == $past(ctl_wbyte[0]) && lo_io_o[NIB_W-1] == $past(ctl_wbyte[2*NIB_W-2]) &&
       up_io_o[0] == $past(ctl_wbyte[1]) && up_io_o[NIB_W-1] == $past(ctl_wbyte[2*NIB_W-1]))); // R2
endmodule

bind qspi_dual_lane_mux qspi_dual_lane_mux_chk #(.NIB_W(NIB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dual_en   (dual_en),
  .rd_sample (rd_sample),
  .ctl_cs_n  (ctl_cs_n),
  .ctl_phase (ctl_phase),
  .ctl_wbyte (ctl_wbyte),
  .rd_valid  (rd_valid),
  .lo_cs_n   (lo_cs_n),
  .lo_io_o   (lo_io_o),
  .lo_io_oe  (lo_io_oe),
  .up_cs_n   (up_cs_n),
  .up_io_o   (up_io_o),
  .up_io_oe  (up_io_oe)
);

// File: tb/qspi_dual_lane_mux_bench.sv
`timescale 1ns/1ps
module qspi_dual_lane_mux_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_sep_bus, cfg_two_mem;
  logic       ctl_cs_n;
  logic [1:0] ctl_phase;
  logic [3:0] ctl_io_out, ctl_io_oe;
  logic [7:0] ctl_wbyte;
  logic       ctl_tick;
  logic [3:0] ctl_io_in;
  logic [7:0] rd_byte;
  logic       rd_valid;
  logic       lo_cs_n, up_cs_n;
  logic [3:0] lo_io_o, lo_io_oe, lo_io_i;
  logic [3:0] up_io_o, up_io_oe, up_io_i;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  qspi_dual_lane_mux u_qspi_dual_lane_mux (
    .clk(clk), .rst_n(rst_n), .cfg_sep_bus(cfg_sep_bus), .cfg_two_mem(cfg_two_mem),
    .ctl_cs_n(ctl_cs_n), .ctl_phase(ctl_phase), .ctl_io_out(ctl_io_out),
    .ctl_io_oe(ctl_io_oe), .ctl_wbyte(ctl_wbyte), .ctl_tick(ctl_tick),
    .ctl_io_in(ctl_io_in), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .lo_cs_n(lo_cs_n), .lo_io_o(lo_io_o), .lo_io_oe(lo_io_oe), .lo_io_i(lo_io_i),
    .up_cs_n(up_cs_n), .up_io_o(up_io_o), .up_io_oe(up_io_oe), .up_io_i(up_io_i)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // even-position bits of a byte packed low-first into a nibble
  function automatic logic [3:0] evens(input logic [7:0] b);
    return {b[6], b[4], b[2], b[0]};
  endfunction
  function automatic logic [3:0] odds(input logic [7:0] b);
    return {b[7], b[5], b[3], b[1]};
  endfunction
  function automatic logic [7:0] weave(input logic [3:0] lo, input logic [3:0] up);
    logic [7:0] r = 8'h00;
    for (int k = 0; k < 4; k++) r = r | ({7'b0, lo[k]} << (2*k)) | ({7'b0, up[k]} << (2*k+1));
    return r;
  endfunction

  // expected {cs_n, oe, o} for one lane given the inputs of the previous cycle
  function automatic logic [8:0] lane_exp(input bit upper, input bit dual, input logic csn,
      input logic [1:0] ph, input logic [3:0] io, input logic [3:0] oe, input logic [7:0] wb);
    if (csn || (upper && !dual)) return {1'b1, 8'h00};
    if (ph == 2'b00) return {1'b0, oe, io};
    if (ph == 2'b01) begin
      if (!dual) return {1'b0, oe, io};
      return {1'b0, 4'hF, upper ? odds(wb) : evens(wb)};
    end
    return {1'b0, 8'h00};
  endfunction

  task automatic tick_clk;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input bit sep, input bit two, input logic csn, input logic [1:0] ph,
      input logic [3:0] io, input logic [3:0] oe, input logic [7:0] wb, input logic tk,
      input logic [3:0] li, input logic [3:0] ui);
    cfg_sep_bus = sep; cfg_two_mem = two; ctl_cs_n = csn; ctl_phase = ph;
    ctl_io_out = io; ctl_io_oe = oe; ctl_wbyte = wb; ctl_tick = tk;
    lo_io_i = li; up_io_i = ui;
  endtask

  // apply current inputs for one cycle and compare all outputs
  task automatic step_check(input string req);
    logic [8:0] el, eu;
    bit dual, smp;
    dual = cfg_sep_bus && cfg_two_mem;
    el = lane_exp(1'b0, dual, ctl_cs_n, ctl_phase, ctl_io_out, ctl_io_oe, ctl_wbyte);
    eu = lane_exp(1'b1, dual, ctl_cs_n, ctl_phase, ctl_io_out, ctl_io_oe, ctl_wbyte);
    smp = dual && !ctl_cs_n && ctl_tick && ctl_phase == 2'b11;
    chk("R6", "ctl_io_in passthrough", {4'h0, ctl_io_in}, {4'h0, lo_io_i});
    tick_clk();
    chk(req, "lower cs/oe/o", {lo_cs_n, lo_io_oe, lo_io_o}, el);
    chk(req, "upper cs/oe/o", {up_cs_n, up_io_oe, up_io_o}, eu);
    chk("R5", "rd_valid", {7'b0, rd_valid}, {7'b0, smp});
    if (smp) chk("R5", "rd_byte", rd_byte, weave(lo_io_i, up_io_i));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    drive(1, 1, 1'b0, 2'b01, 4'h5, 4'hF, 8'hFF, 1'b1, 4'hF, 4'hF);
    rst_n = 1'b0;
    repeat (3) tick_clk();
    // R9 reset state
    chk("R9", "lo_cs_n in reset", {7'b0, lo_cs_n}, 8'h01);
    chk("R9", "up_cs_n in reset", {7'b0, up_cs_n}, 8'h01);
    chk("R9", "oe in reset", {lo_io_oe, up_io_oe}, 8'h00);
    chk("R9", "rd_valid in reset", {7'b0, rd_valid}, 8'h00);
    rst_n = 1'b1;
    drive(1, 1, 1'b1, 2'b00, 4'h0, 4'h0, 8'h00, 1'b0, 4'h0, 4'h0);
    step_check("R8");

    // R4 command broadcast, R3 both selects together
    drive(1, 1, 1'b0, 2'b00, 4'hB, 4'h1, 8'h00, 1'b0, 4'h0, 4'h0);
    step_check("R4");
    chk("R3", "cs pair asserted", {6'b0, lo_cs_n, up_cs_n}, 8'h00);
    // R2 write bytes that expose parity and order errors
    foreach (ctl_wbyte[i]) begin end
    drive(1, 1, 1'b0, 2'b01, 4'h0, 4'h0, 8'h01, 1'b0, 4'h0, 4'h0); step_check("R2");
    chk("R2", "0x01 lower", {4'h0, lo_io_o}, 8'h01);
    drive(1, 1, 1'b0, 2'b01, 4'h0, 4'h0, 8'h02, 1'b0, 4'h0, 4'h0); step_check("R2");
    chk("R2", "0x02 upper", {4'h0, up_io_o}, 8'h01);
    drive(1, 1, 1'b0, 2'b01, 4'h0, 4'h0, 8'h80, 1'b0, 4'h0, 4'h0); step_check("R2");
    chk("R2", "0x80 upper", {4'h0, up_io_o}, 8'h08);
    drive(1, 1, 1'b0, 2'b01, 4'h0, 4'h0, 8'hA5, 1'b0, 4'h0, 4'h0); step_check("R2");
    chk("R2", "0xA5 lo/up", {lo_io_o, up_io_o}, 8'h3C);
    // R7 turnaround releases both buses
    drive(1, 1, 1'b0, 2'b10, 4'hF, 4'hF, 8'hFF, 1'b0, 4'h0, 4'h0); step_check("R7");
    // R5 read merge: lo=0x9 (bits 0,6), up=0x2 (bit 3) -> 0x49
    drive(1, 1, 1'b0, 2'b11, 4'h0, 4'hF, 8'h00, 1'b1, 4'h9, 4'h2); step_check("R5");
    chk("R5", "merged byte", rd_byte, 8'h49);
    drive(1, 1, 1'b0, 2'b11, 4'h0, 4'hF, 8'h00, 1'b0, 4'h6, 4'h6); step_check("R5");
    chk("R5", "strobe dropped", {7'b0, rd_valid}, 8'h00);
    // R3 both selects deassert together
    drive(1, 1, 1'b1, 2'b11, 4'h0, 4'h0, 8'h00, 1'b0, 4'h0, 4'h0); step_check("R3");
    chk("R3", "cs pair released", {6'b0, lo_cs_n, up_cs_n}, 8'h03);

    // R1 only one field set: single mode, write byte ignored
    drive(1, 0, 1'b0, 2'b01, 4'h6, 4'h3, 8'hFF, 1'b1, 4'h0, 4'h0); step_check("R1");
    chk("R1", "sep only lower", {lo_io_oe, lo_io_o}, 8'h36);
    drive(0, 1, 1'b0, 2'b01, 4'h9, 4'hC, 8'h00, 1'b0, 4'h0, 4'h0); step_check("R1");
    chk("R1", "two only upper cs", {7'b0, up_cs_n}, 8'h01);
    // R6 single-mode read: no strobe
    drive(0, 0, 1'b0, 2'b11, 4'h0, 4'h0, 8'h00, 1'b1, 4'hA, 4'h5); step_check("R6");

    // random mix
    void'($urandom(32'h5EED1234));
    for (int n = 0; n < 2000; n++) begin
      int sel;
      sel = $urandom_range(0, 3);
      drive(sel[0] | sel[1], sel[1], ($urandom_range(0, 3) == 0), 2'($urandom),
            4'($urandom), 4'($urandom), 8'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom));
      step_check("R2/R4/R6/R7/R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule